// File: doc/BRIEF.md
# Dual-Output PWM Stage Controller

This block produces two pulse-width-modulated outputs, group A and group B, from one shared counter. The counter runs either as a single up-ramp that wraps to zero (edge-aligned) or as an up-then-down ramp (center-aligned). Each group has its own start and end compare values. Its output is active while the counter value lies inside that window, and its own polarity bit sets which level counts as active. All logic runs on one system clock. A fast and a slow clock-enable input stand in for two clock sources. A select bit picks one of them, and a prescaler then passes one of every 1, 4, 32 or 256 of its pulses to the counter.

Software reaches the block through a byte-wide register port. The compare values, the period value and the output-enable register are double-buffered. Software writes a shadow copy, and the working copy takes it over only at a period boundary, or at any time while the counter is stopped. An update-lock bit holds back that copy, so a complete new set of values can be staged and then released at once without breaking a running period.

Top module: `pwm_dual_stage`

## Requirements
- R1: After reset every register reads 0. Both outputs are disabled and sit at their inactive level, which is high, because the polarity bits reset to 0.
- R2: While the run bit (address 1, bit 0) is 0, both outputs are held at their inactive level. When run goes from 0 to 1, the counter starts from zero, and the output takes the value for count 0 in the first cycle after the write.
- R3: With the mode bit (address 0, bit 4) at 0, the counter ramps 0..TOP and wraps. One period lasts (TOP+1) counter steps. TOP is at address 6.
- R4: With the mode bit at 1, the counter ramps 0..TOP..1 and returns to 0. One period lasts 2*TOP counter steps.
- R5: A group is active while START <= count < END. A's START and END are at addresses 2 and 3, and B's are at 4 and 5. Output-enable bits sit at address 7: bit 0 for A, bit 1 for B. A disabled group stays inactive.
- R6: Polarity bit A (address 0, bit 2) and polarity bit B (address 0, bit 3) are independent. At 1 the group is active high, and at 0 it is active low.
- R7: The prescaler code (address 1, bits 7:6) sets how many selected enable pulses make one counter step: 00 gives 1, 01 gives 4, 10 gives 32 and 11 gives 256. Periods and pulse widths scale by that factor.
- R8: The clock-select bit (address 1, bit 5) picks the fast enable input when it is 1 and the slow enable input when it is 0. The enable input that is not selected has no effect.
- R9: While the update-lock bit (address 0, bit 5) is 1, writes to addresses 2..7 change only the shadow copies, which read back at once. The running waveform keeps its period and pulse width.
- R10: Once lock is 0, all shadow values move to the working registers together at the next period boundary, never in the middle of a period.
- R11: Reserved bits read as 0: address 0 bits 7:6 and 1:0, address 1 bits 4:1, and address 7 bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| ce_fast | input | 1 | Fast clock-enable source |
| ce_slow | input | 1 | Slow clock-enable source |
| out_a | output | 1 | Group A PWM output |
| out_b | output | 1 | Group B PWM output |

## Verification
The bench measures whole periods and pulse widths for both ramp modes under every prescaler code. A wrong prescaler ratio, or a center ramp that reused count 0 or TOP, would give periods off by a factor or by one step. The lock test stages a new END and a new TOP, and expects the old waveform to continue and then both new values to appear in the same period. A design that copied the shadows early would show the new width under lock, and one that copied them one at a time could show a new width with the old period. Further checks cover disabled groups, mixed polarity, a restart from zero on the run edge, and an enable input that is not selected being frozen out.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;

  typedef enum logic [2:0] {
    ADR_CFG  = 3'd0,
    ADR_CTL  = 3'd1,
    ADR_SETA = 3'd2,
    ADR_RSTA = 3'd3,
    ADR_SETB = 3'd4,
    ADR_RSTB = 3'd5,
    ADR_TOP  = 3'd6,
    ADR_OCFG = 3'd7
  } reg_addr_e;

  localparam int NCMP  = 5;  // setA, rstA, setB, rstB, top
  localparam int DIV_W = 8;  // wide enough for the largest ratio minus one

  // last prescaler count before a counter step (ratio - 1)
  function automatic logic [DIV_W-1:0] div_limit(input logic [1:0] code);
    case (code)
      2'd0:    div_limit = 8'd0;
      2'd1:    div_limit = 8'd3;
      2'd2:    div_limit = 8'd31;
      default: div_limit = 8'd255;
    endcase
  endfunction

endpackage

// File: rtl/pwm_psc_div.sv
module pwm_psc_div
  import pwm_stage_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       src_en,
  input  logic [1:0] code,
  output logic       tick
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] lim;

  assign lim  = div_limit(code);
  assign tick = src_en && !clr && (pre_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre_q <= '0;
    else if (clr)             pre_q <= '0;
    else if (src_en) begin
      if (pre_q >= lim)       pre_q <= '0;
      else                    pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_ramp_cnt.sv
module pwm_ramp_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             center,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary
);
  logic up_q;

  always_comb begin
    if (!tick)        boundary = 1'b0;
    else if (!center) boundary = (cnt >= top);
    else              boundary = (top == '0) || (!up_q && cnt <= 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      up_q <= 1'b1;
    end else if (clr) begin
      cnt  <= '0;
      up_q <= 1'b1;
    end else if (tick) begin
      if (!center || top == '0) begin
        up_q <= 1'b1;
        cnt  <= (cnt >= top) ? '0 : cnt + 1'b1;
      end else if (up_q) begin
        if (cnt >= top) begin
          cnt  <= top - 1'b1;
          up_q <= 1'b0;
        end else begin
          cnt  <= cnt + 1'b1;
        end
      end else if (cnt <= 1) begin
        cnt  <= '0;
        up_q <= 1'b1;
      end else begin
        cnt  <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_out_cmp.sv
module pwm_out_cmp #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] set_v,
  input  logic [CNT_W-1:0] rst_v,
  input  logic             en,
  input  logic             run,
  input  logic             pol,
  output logic             active,
  output logic             out
);
  assign active = run && en && (cnt >= set_v) && (cnt < rst_v);
  assign out    = pol ? active : !active;
endmodule

// File: rtl/pwm_dual_stage.sv
module pwm_dual_stage
  import pwm_stage_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ce_fast,
  input  logic             ce_slow,
  output logic             out_a,
  output logic             out_b
);
  // configuration and control
  logic       lock_q, center_q, pol_a_q, pol_b_q;
  logic [1:0] psc_q;
  logic       sel_q, run_q;

  // double-buffered compare/period and output enables
  logic [CNT_W-1:0] sh_cmp [NCMP];
  logic [CNT_W-1:0] wk_cmp [NCMP];
  logic [1:0]       sh_oc, wk_oc;

  // named internal events
  logic             src_en, tick, boundary, commit;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       pol_v, act_v, out_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {lock_q, center_q, pol_a_q, pol_b_q} <= '0;
      {psc_q, sel_q, run_q} <= '0;
      sh_oc <= '0;
      for (int i = 0; i < NCMP; i++) sh_cmp[i] <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        ADR_CFG: begin
          lock_q   <= wr_data[5];
          center_q <= wr_data[4];
          pol_b_q  <= wr_data[3];
          pol_a_q  <= wr_data[2];
        end
        ADR_CTL: begin
          psc_q <= wr_data[7:6];
          sel_q <= wr_data[5];
          run_q <= wr_data[0];
        end
        ADR_OCFG: sh_oc <= wr_data[1:0];
        default:  sh_cmp[int'(wr_addr) - 2] <= wr_data;
      endcase
    end
  end

  assign commit = !lock_q && (boundary || !run_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_oc <= '0;
      for (int i = 0; i < NCMP; i++) wk_cmp[i] <= '0;
    end else if (commit) begin
      wk_oc <= sh_oc;
      for (int i = 0; i < NCMP; i++) wk_cmp[i] <= sh_cmp[i];
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      ADR_CFG:  begin
        rd_data[5] = lock_q;
        rd_data[4] = center_q;
        rd_data[3] = pol_b_q;
        rd_data[2] = pol_a_q;
      end
      ADR_CTL:  begin
        rd_data[7:6] = psc_q;
        rd_data[5]   = sel_q;
        rd_data[0]   = run_q;
      end
      ADR_OCFG: rd_data[1:0] = sh_oc;
      default:  rd_data = sh_cmp[int'(rd_addr) - 2];
    endcase
  end

  assign src_en = sel_q ? ce_fast : ce_slow;

  pwm_psc_div u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!run_q),
    .src_en (src_en),
    .code   (psc_q),
    .tick   (tick)
  );

  pwm_ramp_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!run_q),
    .tick     (tick),
    .center   (center_q),
    .top      (wk_cmp[4]),
    .cnt      (cnt_q),
    .boundary (boundary)
  );

  assign pol_v = {pol_b_q, pol_a_q};

  for (genvar g = 0; g < 2; g++) begin : g_grp
    pwm_out_cmp #(.CNT_W(CNT_W)) u_oc (
      .cnt    (cnt_q),
      .set_v  (wk_cmp[2*g]),
      .rst_v  (wk_cmp[2*g+1]),
      .en     (wk_oc[g]),
      .run    (run_q),
      .pol    (pol_v[g]),
      .active (act_v[g]),
      .out    (out_v[g])
    );
  end

  assign out_a = out_v[0];
  assign out_b = out_v[1];
endmodule

// File: rtl/pwm_dual_stage_chk.sv
module pwm_dual_stage_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             lock,
  input logic             center,
  input logic             clksel,
  input logic             ce_fast,
  input logic             ce_slow,
  input logic             tick,
  input logic             boundary,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] wk_top,
  input logic [CNT_W-1:0] wk_seta,
  input logic [CNT_W-1:0] wk_rsta,
  input logic             pol_a,
  input logic             pol_b,
  input logic             out_a,
  input logic             out_b,
  input logic [2:0]       rd_addr,
  input logic [CNT_W-1:0] rd_data
);
  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (out_a == !pol_a) && (out_b == !pol_b)); // R2

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (clksel ? ce_fast : ce_slow)); // R8

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= wk_top); // R3

  AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !center && boundary) |=> (cnt == '0)); // R3

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> ($stable(wk_top) && $stable(wk_seta) && $stable(wk_rsta))); // R9

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd0) |-> (rd_data[7:6] == 2'b00 && rd_data[1:0] == 2'b00)); // R11
endmodule

bind pwm_dual_stage pwm_dual_stage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run_q),
  .lock     (lock_q),
  .center   (center_q),
  .clksel   (sel_q),
  .ce_fast  (ce_fast),
  .ce_slow  (ce_slow),
  .tick     (tick),
  .boundary (boundary),
  .cnt      (cnt_q),
  .wk_top   (wk_cmp[4]),
  .wk_seta  (wk_cmp[0]),
  .wk_rsta  (wk_cmp[1]),
  .pol_a    (pol_a_q),
  .pol_b    (pol_b_q),
  .out_a    (out_a),
  .out_b    (out_b),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data)
);

// File: tb/sim_pwm_dual_stage.sv
module sim_pwm_dual_stage;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ce_fast = 1'b1;
  logic       ce_slow = 1'b0;
  logic       out_a, out_b;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  pwm_dual_stage #(.CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ce_fast(ce_fast), .ce_slow(ce_slow),
    .out_a(out_a), .out_b(out_b)
  );

  always #4 clk = ~clk;  // 125 MHz
  always @(negedge clk) ce_slow <= ~ce_slow;  // half-rate slow source

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  typedef struct packed {
    logic       mode;
    logic [1:0] psc;
    logic       sel;
    logic [7:0] top;
    logic [7:0] sv;
    logic [7:0] rv;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b1, 8'd4, 8'd1, 8'd3},
    '{1'b0, 2'd1, 1'b1, 8'd4, 8'd1, 8'd3},
    '{1'b0, 2'd2, 1'b1, 8'd4, 8'd1, 8'd3},
    '{1'b0, 2'd3, 1'b1, 8'd4, 8'd1, 8'd3},
    '{1'b1, 2'd0, 1'b1, 8'd4, 8'd2, 8'd5},
    '{1'b1, 2'd1, 1'b1, 8'd4, 8'd2, 8'd5},
    '{1'b1, 2'd2, 1'b1, 8'd4, 8'd2, 8'd5},
    '{1'b1, 2'd3, 1'b1, 8'd4, 8'd2, 8'd5},
    '{1'b0, 2'd1, 1'b0, 8'd6, 8'd0, 8'd4},
    '{1'b1, 2'd0, 1'b0, 8'd5, 8'd1, 8'd6}
  };

  function automatic int ratio(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 32;
      default: return 256;
    endcase
  endfunction

  // walk one period of the ramp and count steps inside the window
  function automatic int hi_steps(input logic m, input int top, input int s, input int r);
    int n = 0;
    for (int v = 0; v <= top; v++) if (v >= s && v < r) n++;
    if (m) for (int v = top - 1; v >= 1; v--) if (v >= s && v < r) n++;
    return n;
  endfunction

  function automatic int per_steps(input logic m, input int top);
    return m ? 2 * top : top + 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  // measure one full active-high pulse and the gap after it on out_a
  task automatic measure(output int hi, output int per);
    int guard = 0;
    hi = 0; per = 0;
    @(negedge clk);
    while (out_a !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    while (out_a !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    hi = 1;
    forever begin
      @(negedge clk); guard++;
      if (out_a !== 1'b1 || guard >= 20000) break;
      hi++;
    end
    per = hi + 1;
    forever begin
      @(negedge clk); guard++;
      if (out_a !== 1'b0 || guard >= 20000) break;
      per++;
    end
  endtask

  initial begin
    logic [7:0] d;
    int hi, per, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 out_a idle", int'(out_a), 1);
    chk("R1 out_b idle", int'(out_b), 1);
    rd(3'd0, d); chk("R1 cfg", int'(d), 0);
    rd(3'd1, d); chk("R1 ctl", int'(d), 0);
    rd(3'd6, d); chk("R1 top", int'(d), 0);

    // R11: reserved bits
    wr(3'd0, 8'hFF); rd(3'd0, d); chk("R11 cfg", int'(d), 8'h3C);
    wr(3'd1, 8'hFE); rd(3'd1, d); chk("R11 ctl", int'(d), 8'hE0);
    wr(3'd7, 8'hFF); rd(3'd7, d); chk("R11 ocfg", int'(d), 8'h03);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);

    // R3 R4 R7 R8: period and width table
    for (int i = 0; i < NV; i++) begin
      int k;
      vec_t v;
      v = VECS[i];
      k = ratio(v.psc) * (v.sel ? 1 : 2);
      wr(3'd1, 8'h00);
      wr(3'd0, {3'b000, v.mode, 2'b11, 2'b00});
      wr(3'd2, v.sv); wr(3'd3, v.rv);
      wr(3'd4, v.sv); wr(3'd5, v.rv);
      wr(3'd6, v.top); wr(3'd7, 8'h03);
      wr(3'd1, {v.psc, v.sel, 4'b0000, 1'b1});
      measure(hi, per);
      chk(v.mode ? "R4 R7 width" : "R3 R7 width", hi,
          hi_steps(v.mode, int'(v.top), int'(v.sv), int'(v.rv)) * k);
      chk(v.sel ? (v.mode ? "R4 R7 period" : "R3 R7 period") : "R8 period", per,
          per_steps(v.mode, int'(v.top)) * k);
    end

    // R2: stop forces idle, restart begins at count zero
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h0C);
    wr(3'd2, 8'd0); wr(3'd3, 8'd3); wr(3'd6, 8'd9); wr(3'd7, 8'h03);
    chk("R2 stopped", int'(out_a), 0);
    wr(3'd1, 8'h21);
    chk("R2 count0", int'(out_a), 1);
    @(negedge clk); @(negedge clk);
    chk("R2 count2", int'(out_a), 1);
    @(negedge clk);
    chk("R2 count3", int'(out_a), 0);

    // R9 R10: staged under lock, released together at boundary
    measure(hi, per);
    chk("R5 window", hi, 3);
    wr(3'd0, 8'h2C);
    wr(3'd3, 8'd7); wr(3'd6, 8'd11);
    rd(3'd3, d); chk("R9 shadow readback", int'(d), 7);
    measure(hi, per);
    chk("R9 width held", hi, 3);
    chk("R9 period held", per, 10);
    wr(3'd0, 8'h0C);
    measure(hi, per);
    chk("R10 new width", hi, 7);
    chk("R10 new period", per, 12);

    // R6: mixed polarity, A active low, B active high
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h08);
    wr(3'd2, 8'd0); wr(3'd3, 8'd5); wr(3'd4, 8'd0); wr(3'd5, 8'd5);
    wr(3'd6, 8'd9); wr(3'd7, 8'h03);
    chk("R6 idle A", int'(out_a), 1);
    chk("R6 idle B", int'(out_b), 0);
    wr(3'd1, 8'h21);
    n = 0; hi = 0;
    for (int j = 0; j < 24; j++) begin
      if (j > 0) @(negedge clk);
      if (out_a == out_b) n++;
      if (out_a == 1'b0) hi++;
    end
    chk("R6 complementary", n, 0);
    chk("R6 A low count", hi, 14);

    // R5: disabled group B stays inactive
    wr(3'd1, 8'h00);
    wr(3'd7, 8'h01);
    wr(3'd1, 8'h21);
    n = 0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (out_b == 1'b1) n++;
    end
    chk("R5 B disabled", n, 0);

    // R8: fast source held off freezes the output
    wr(3'd0, 8'h04);
    wr(3'd1, 8'h00);
    wr(3'd7, 8'h01);
    ce_fast = 1'b0;
    wr(3'd1, 8'h21);
    n = 0;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (out_a != 1'b1) n++;
    end
    chk("R8 frozen", n, 0);
    ce_fast = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule